// File: doc/BRIEF.md
# Rotating Search-Window Loader

This block holds the reference pixels that a block-matching motion search examines. It keeps three identical window memories. Each memory is 32×32 pixels and is stored as an 8×8 grid of 4×4 pixel blocks. A 128-bit beat carries one 4×4 block, which is 16 pixels of 8 bits. While one memory is being searched, a second is being loaded. The third receives the part of the window that the next macroblock will share.

Horizontally adjacent 16×16 macroblocks have search windows that are offset by 16 columns, so half of each window is common to its neighbour. Every beat that lands in the right half of the window being loaded is also written into the left half of the following memory. Only the first window of a row needs a full 64-beat load. Each later window needs only its 32 right-half beats, so the next window is ready before the search finishes with the current one.

The memories rotate in round-robin order for loading and for searching. A search controller reads 4×4 blocks from the active memory and signals the end of each macroblock. That signal releases the memory and moves reading on to the next one.

Top module: `sa_tribank_loader`

## Requirements
- R1: After reset, no memory is ready, `rd_ready_o` is low, `wr_ready_o` is high, and both the load pointer and the read pointer are 0.
- R2: A full load takes 64 accepted beats, one per block, in block index order 0 to 63. The block index is 8×block_row + block_col. Pixel (r,c) of a block sits at bits [8×(4r+c) +: 8]. The first load after reset is a full load.
- R3: A reuse load takes 32 accepted beats and covers only the right-half blocks (block_col 4 to 7), in row-major order. Every load after the first is a reuse load unless R10 applies.
- R4: Every accepted beat whose block_col is 4 or more is also written into the successor memory at block_col−4 of the same row. A reuse-loaded memory therefore holds the window shifted by 16 pixel columns from its predecessor.
- R5: A memory's bit in `bank_ready_o` rises in the cycle after the last beat of its load is accepted. It falls in the cycle after an accepted `mb_done_i` that releases that memory.
- R6: The load pointer advances 0→1→2→0 when a load completes. The read pointer advances the same way on an accepted `mb_done_i`. Both pointers appear on `wr_bank_o` and `rd_bank_o`.
- R7: `wr_ready_o` is low while the successor of the load memory is the read memory. Beats offered in that state are not taken and change nothing.
- R8: `rd_ready_o` equals the ready bit of the read memory. A request made while it is high returns the block on `rd_data_o` with `rd_valid_o` high in the next cycle. A request made while it is low is ignored.
- R9: `mb_done_i` is ignored while the read memory is not ready.
- R10: A `row_start_i` pulse given while no beat of the current load has been accepted, and with no beat taken in the same cycle, makes that load a full load (R2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| row_start_i | input | 1 | Forces the pending load to be a full load |
| wr_valid_i | input | 1 | Load beat offered |
| wr_data_i | input | 128 | One 4×4 pixel block |
| wr_ready_o | output | 1 | Load beat can be taken |
| mb_done_i | input | 1 | Search of the read memory finished |
| rd_req_i | input | 1 | Block read request |
| rd_blk_i | input | 6 | Block index, 8×row + column |
| rd_ready_o | output | 1 | Read memory holds a complete window |
| rd_valid_o | output | 1 | `rd_data_o` carries a requested block |
| rd_data_o | output | 128 | Returned 4×4 block |
| bank_ready_o | output | 3 | Per-memory ready flags |
| wr_bank_o | output | 2 | Memory being loaded |
| rd_bank_o | output | 2 | Memory being read |

## Verification
The hardest state to reach is the one where the loader has got a full window ahead of the search. In that state the overlap copy would land in the memory still being read, so loading must stall. The stimulus loads two windows back to back without releasing the first, offers a beat, and checks that the beat is refused. Only after the release does it let the third load go ahead. That third load wraps the overlap copy around into memory 0.

Memory 0 is later read out as a reuse window, so its left half comes from that wrapped copy. A later row restart checks that a full load overwrites a left half that was already copied.

// File: rtl/sal_pkg.sv
package sal_pkg;
  localparam int unsigned NUM_BANKS = 3;
  typedef logic [1:0] bank_t;

  function automatic bank_t bank_next(bank_t b);
    return (b == bank_t'(NUM_BANKS - 1)) ? '0 : b + 2'd1;
  endfunction
endpackage

// File: rtl/sal_bank.sv
module sal_bank #(
  parameter int unsigned W     = 128,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sal_fill_seq.sv
module sal_fill_seq #(
  parameter int unsigned WIN_BLKS = 8,
  parameter int unsigned AW       = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          beat_i,
  input  logic          row_start_i,
  output logic [AW-1:0] blk_o,
  output logic          copy_o,
  output logic [AW-1:0] copy_blk_o,
  output logic          last_o
);
  localparam int unsigned CB    = AW / 2;
  localparam int unsigned DEPTH = WIN_BLKS * WIN_BLKS;

  logic [AW-1:0] cnt_q;
  logic          full_q;
  logic [CB-1:0] row, col;

  // reuse loads walk only the right-half columns
  always_comb begin
    if (full_q) begin
      row = cnt_q[AW-1:CB];
      col = cnt_q[CB-1:0];
    end else begin
      row = cnt_q[AW-2:CB-1];
      col = {1'b1, cnt_q[CB-2:0]};
    end
  end

  assign blk_o      = {row, col};
  assign copy_o     = col[CB-1];
  assign copy_blk_o = {row, 1'b0, col[CB-2:0]};
  assign last_o     = full_q ? (cnt_q == AW'(DEPTH - 1)) : (cnt_q == AW'(DEPTH / 2 - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      full_q <= 1'b1;
    end else if (beat_i) begin
      if (last_o) begin
        cnt_q  <= '0;
        full_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (row_start_i && cnt_q == '0) begin
      full_q <= 1'b1;
    end
  end

  // R2
  full_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && full_q && cnt_q == AW'(DEPTH / 2 - 1)) |-> !last_o);
endmodule

// File: rtl/sal_ring_ctrl.sv
module sal_ring_ctrl import sal_pkg::*; (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fill_done_i,
  input  logic                 mb_done_i,
  output bank_t                wr_ptr_o,
  output bank_t                rd_ptr_o,
  output bank_t                nxt_ptr_o,
  output logic [NUM_BANKS-1:0] ready_o,
  output logic                 wr_ok_o,
  output logic                 rd_ok_o
);
  bank_t                wr_q, rd_q;
  logic [NUM_BANKS-1:0] ready_q;
  logic                 release_w;

  assign release_w = mb_done_i && ready_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      ready_q <= '0;
    end else begin
      if (fill_done_i) begin
        ready_q[wr_q] <= 1'b1;
        wr_q          <= bank_next(wr_q);
      end
      if (release_w) begin
        ready_q[rd_q] <= 1'b0;
        rd_q          <= bank_next(rd_q);
      end
    end
  end

  assign nxt_ptr_o = bank_next(wr_q);
  // the overlap copy must never land in the bank under search
  assign wr_ok_o   = (nxt_ptr_o != rd_q);
  assign rd_ok_o   = ready_q[rd_q];
  assign wr_ptr_o  = wr_q;
  assign rd_ptr_o  = rd_q;
  assign ready_o   = ready_q;

  // R6
  ptr_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q != 2'd3) && (rd_q != 2'd3));

  // R9
  ignored_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_done_i && !ready_q[rd_q]) |=> $stable(rd_q));
endmodule

// File: rtl/sa_tribank_loader.sv
module sa_tribank_loader import sal_pkg::*; #(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned BLK_SIDE = 4,
  parameter int unsigned WIN_BLKS = 8,
  localparam int unsigned BEAT_W  = PIX_W * BLK_SIDE * BLK_SIDE,
  localparam int unsigned AW      = 2 * $clog2(WIN_BLKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 row_start_i,
  input  logic                 wr_valid_i,
  input  logic [BEAT_W-1:0]    wr_data_i,
  output logic                 wr_ready_o,
  input  logic                 mb_done_i,
  input  logic                 rd_req_i,
  input  logic [AW-1:0]        rd_blk_i,
  output logic                 rd_ready_o,
  output logic                 rd_valid_o,
  output logic [BEAT_W-1:0]    rd_data_o,
  output logic [NUM_BANKS-1:0] bank_ready_o,
  output logic [1:0]           wr_bank_o,
  output logic [1:0]           rd_bank_o
);
  localparam int unsigned DEPTH = WIN_BLKS * WIN_BLKS;

  bank_t                wr_ptr, rd_ptr, nxt_ptr;
  logic [NUM_BANKS-1:0] ready;
  logic                 wr_ok, rd_ok;
  logic                 beat, rd_take;
  logic [AW-1:0]        fill_blk, copy_blk;
  logic                 copy_en, fill_last;
  logic [BEAT_W-1:0]    bank_rdata [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_we;
  bank_t                rd_sel_q;
  logic                 rd_valid_q;

  assign beat    = wr_valid_i && wr_ok;
  assign rd_take = rd_req_i && rd_ok;

  sal_fill_seq #(.WIN_BLKS(WIN_BLKS), .AW(AW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_i     (beat),
    .row_start_i(row_start_i),
    .blk_o      (fill_blk),
    .copy_o     (copy_en),
    .copy_blk_o (copy_blk),
    .last_o     (fill_last)
  );

  sal_ring_ctrl u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fill_done_i(beat && fill_last),
    .mb_done_i  (mb_done_i),
    .wr_ptr_o   (wr_ptr),
    .rd_ptr_o   (rd_ptr),
    .nxt_ptr_o  (nxt_ptr),
    .ready_o    (ready),
    .wr_ok_o    (wr_ok),
    .rd_ok_o    (rd_ok)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel_p, sel_c;
    assign sel_p      = (wr_ptr == bank_t'(g));
    assign sel_c      = copy_en && (nxt_ptr == bank_t'(g));
    assign bank_we[g] = beat && (sel_p || sel_c);

    sal_bank #(.W(BEAT_W), .DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (bank_we[g]),
      .waddr_i(sel_p ? fill_blk : copy_blk),
      .wdata_i(wr_data_i),
      .re_i   (rd_take && (rd_ptr == bank_t'(g))),
      .raddr_i(rd_blk_i),
      .rdata_o(bank_rdata[g])
    );

    // R7
    no_write_ready_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_we[g] |-> !ready[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_sel_q   <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_take;
      if (rd_take) rd_sel_q <= rd_ptr;
    end
  end

  assign rd_data_o    = bank_rdata[rd_sel_q];
  assign rd_valid_o   = rd_valid_q;
  assign rd_ready_o   = rd_ok;
  assign wr_ready_o   = wr_ok;
  assign bank_ready_o = ready;
  assign wr_bank_o    = wr_ptr;
  assign rd_bank_o    = rd_ptr;

  // R8
  stalled_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !rd_ready_o) |=> !rd_valid_o);

  // R5
  ready_on_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat && fill_last) |=> bank_ready_o[$past(wr_ptr)]);

  // R4
  copy_not_read_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat && copy_en && rd_ok) |-> !bank_we[rd_ptr]);
endmodule

// File: tb/sa_tribank_loader_bench.sv
module sa_tribank_loader_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         row_start = 1'b0;
  logic         wr_valid = 1'b0;
  logic [127:0] wr_data = '0;
  logic         wr_ready;
  logic         mb_done = 1'b0;
  logic         rd_req = 1'b0;
  logic [5:0]   rd_blk = '0;
  logic         rd_ready, rd_valid;
  logic [127:0] rd_data;
  logic [2:0]   bank_ready;
  logic [1:0]   wr_bank, rd_bank;

  sa_tribank_loader u_sa_tribank_loader (
    .clk_i(clk), .rst_ni(rst_n), .row_start_i(row_start),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .mb_done_i(mb_done), .rd_req_i(rd_req), .rd_blk_i(rd_blk),
    .rd_ready_o(rd_ready), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .bank_ready_o(bank_ready), .wr_bank_o(wr_bank), .rd_bank_o(rd_bank)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pix(int row, int x, int y);
    return 8'((row * 37 + x * 5 + y * 11 + x * y) & 255);
  endfunction

  function automatic logic [127:0] blk_data(int row, int mb, int blk);
    logic [127:0] d;
    int br, bc;
    br = blk / 8;
    bc = blk % 8;
    d  = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        d[8*(4*r+c) +: 8] = pix(row, 16 * mb + 4 * bc + c, 4 * br + r);
    return d;
  endfunction

  // behavioural reference
  int           m_wr, m_rd, m_cnt;
  bit           m_full;
  bit           m_ready [3];
  bit           m_rv;
  logic [127:0] exp_q [$];
  string        tag_q [$];
  int           bank_row [3];
  int           bank_mb [3];
  string        bank_tag [3];
  bit           bank_full [3];

  always @(posedge clk or negedge rst_n) begin : model
    bit wr_rdy, fin, rd_take, rel;
    int beats;
    if (!rst_n) begin
      m_wr = 0; m_rd = 0; m_cnt = 0; m_full = 1'b1; m_rv = 1'b0;
      for (int i = 0; i < 3; i++) m_ready[i] = 1'b0;
    end else begin
      wr_rdy  = ((m_wr + 1) % 3) != m_rd;
      beats   = m_full ? 64 : 32;
      rd_take = rd_req && m_ready[m_rd];
      rel     = mb_done && m_ready[m_rd];
      fin     = 1'b0;
      if (wr_valid && wr_rdy) begin
        if (m_cnt == beats - 1) fin = 1'b1;
        else m_cnt++;
      end else if (row_start && m_cnt == 0) begin
        m_full = 1'b1;
      end
      m_rv = rd_take;
      if (rd_take) begin
        exp_q.push_back(blk_data(bank_row[m_rd], bank_mb[m_rd], int'(rd_blk)));
        if (bank_full[m_rd]) tag_q.push_back(bank_tag[m_rd]);
        else if (rd_blk[2]) tag_q.push_back("R3");
        else tag_q.push_back("R4");
      end
      if (fin) begin
        m_ready[m_wr] = 1'b1;
        m_wr = (m_wr + 1) % 3;
        m_cnt = 0;
        m_full = 1'b0;
      end
      if (rel) begin
        m_ready[m_rd] = 1'b0;
        m_rd = (m_rd + 1) % 3;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(wr_ready == (((m_wr + 1) % 3) != m_rd), "R7", "wr_ready", 128'(wr_ready), 128'(((m_wr + 1) % 3) != m_rd));
      chk(rd_ready == m_ready[m_rd], "R8", "rd_ready", 128'(rd_ready), 128'(m_ready[m_rd]));
      chk(bank_ready == {m_ready[2], m_ready[1], m_ready[0]}, "R5", "bank_ready",
          128'(bank_ready), 128'({m_ready[2], m_ready[1], m_ready[0]}));
      chk(int'(wr_bank) == m_wr && int'(rd_bank) == m_rd, "R6", "pointers",
          128'({wr_bank, rd_bank}), 128'({2'(m_wr), 2'(m_rd)}));
      chk(rd_valid == m_rv, "R8", "rd_valid", 128'(rd_valid), 128'(m_rv));
      if (rd_valid && exp_q.size() > 0) begin
        logic [127:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data == e, t, "rd_data", rd_data, e);
      end
    end
  end

  task automatic send(logic [127:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fill(int row, int mb, bit full, string ftag);
    int n, blk;
    bank_row[m_wr]  = row;
    bank_mb[m_wr]   = mb;
    bank_full[m_wr] = full;
    bank_tag[m_wr]  = ftag;
    n = full ? 64 : 32;
    for (int i = 0; i < n; i++) begin
      blk = full ? i : (i / 4) * 8 + 4 + (i % 4);
      send(blk_data(row, mb, blk));
    end
    wr_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_bank();
    for (int b = 0; b < 64; b++) begin
      rd_req = 1'b1;
      rd_blk = 6'(b);
      @(negedge clk);
    end
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_done();
    mb_done = 1'b1;
    @(negedge clk);
    mb_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bank_ready == 3'b000 && !rd_ready && wr_ready && wr_bank == 2'd0 && rd_bank == 2'd0,
        "R1", "reset state", 128'({bank_ready, rd_ready, wr_ready, wr_bank, rd_bank}), 128'(8'b000_0_1_00_00 >> 0) << 0);

    // R9 release before anything is ready
    pulse_done();
    chk(rd_bank == 2'd0 && bank_ready == 3'b000, "R9", "early mb_done", 128'(rd_bank), 128'd0);

    // R8 read of a bank that is not ready
    rd_req = 1'b1; rd_blk = 6'd5;
    @(negedge clk);
    rd_req = 1'b0;
    chk(!rd_valid, "R8", "stalled read", 128'(rd_valid), 128'd0);

    fill(0, 0, 1'b1, "R2");
    fill(0, 1, 1'b0, "R2");

    // R7 loader one window ahead: offered beats must be refused
    wr_valid = 1'b1;
    wr_data  = {4{32'hDEAD_BEEF}};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!wr_ready && wr_bank == 2'd2, "R7", "stall when ahead", 128'({wr_ready, wr_bank}), 128'({1'b0, 2'd2}));
    end
    wr_valid = 1'b0;
    @(negedge clk);

    read_bank();
    pulse_done();
    fill(0, 2, 1'b0, "R2");
    read_bank();
    pulse_done();
    fill(0, 3, 1'b0, "R2");
    read_bank();
    pulse_done();
    read_bank();           // bank 0 with left half copied from the wrapped fill
    pulse_done();
    chk(rd_bank == 2'd1 && wr_bank == 2'd1, "R6", "rotation wrap", 128'({rd_bank, wr_bank}), 128'({2'd1, 2'd1}));

    // R10 new row: forced full load over a copied left half
    row_start = 1'b1;
    @(negedge clk);
    row_start = 1'b0;
    fill(1, 0, 1'b1, "R10");
    read_bank();
    fill(1, 1, 1'b0, "R10");
    pulse_done();
    read_bank();
    pulse_done();
    chk(exp_q.size() == 0, "R8", "all reads answered", 128'(exp_q.size()), 128'd0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule